// File: doc/BRIEF.md
# Endian-Configurable Sub-Word Memory Port

This block is a byte-addressable data store built from 32-bit words, with one load/store port for a processor. Each access moves a single byte, a half-word or a whole word. Where the bytes of a multi-byte value sit inside a stored word depends on a byte-order mode. That mode is captured while reset is held and stays fixed until the next reset.

Writes update only the byte lanes the access covers. Every cycle also performs a read of the addressed word, and the result appears one clock later. A byte or half-word result is widened to 32 bits, with sign or zero fill chosen by a per-access flag. Accesses that are not aligned to their own size raise an error flag in the same cycle. Such an access writes nothing, and the read data that follows it is zero.

Top module: `mem_subword_port`

## Requirements
- R1: The word index is `addr_i[IDX_W+1:2]` with IDX_W = log2(DEPTH), default DEPTH 256. Address bits above that index are ignored, so 0x400 aliases 0x000 by default. The read result for a request is on `rdata_o` one clock after the request is presented.
- R2: With little-endian order (`endian_sel_i` = 0 when reset is released), the byte at address offset k (the low two address bits) occupies bits 8k+7..8k of the stored word. A half-word at offset 0 uses bits 15..0, and one at offset 2 uses bits 31..16, with the lower address holding the less significant byte.
- R3: With big-endian order (`endian_sel_i` = 1 when reset is released), the byte at offset k occupies bits 8(3-k)+7..8(3-k). A half-word at offset 0 uses bits 31..16, and one at offset 2 uses bits 15..0, with the lower address holding the more significant byte.
- R4: `endian_sel_i` is sampled on every clock edge while `rst_n` is low, and the last sampled value is held. Changes on `endian_sel_i` while `rst_n` is high have no effect.
- R5: A write (`we_i` = 1) changes only the bytes it covers. All other bytes of the word keep their contents. When `we_i` = 0, nothing is written.
- R6: `size_i` encodes 0 = byte, 1 = half-word, 2 = word, 3 = word. A byte or half-word result is sign-extended when `signed_i` = 1 and zero-extended when `signed_i` = 0.
- R7: `err_o` is high in the same cycle whenever a half-word has `addr_i[0]` = 1, or a word (size 2 or 3) has `addr_i[1:0]` not equal to 0. Such an access writes nothing, and the `rdata_o` that follows it is 0.
- R8: A write cycle also reads. The `rdata_o` that follows it shows the word as it was before that write.
- R9: `rdata_o` is 0 while `rst_n` is low and in the first cycle after release. The stored contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| endian_sel_i | input | 1 | Byte-order choice captured during reset: 0 = little, 1 = big |
| addr_i | input | 32 | Byte address of the access |
| size_i | input | 2 | Access size code |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write value, right-aligned |
| signed_i | input | 1 | Sign-extend narrow read results |
| rdata_o | output | 32 | Widened read result, one cycle after the request |
| err_o | output | 1 | Misaligned access in the current cycle |

## Verification
A word of distinct bytes is written once. It is then read back as bytes and half-words at every offset, in both orders. This separates lane steering that is merely plausible from lane steering that is correct, and it confirms that word traffic looks the same in either mode. Narrow writes into an already filled word show whether only the addressed lanes change. Sign and zero widening are each tried on values with the top bit set and clear, which tells the two kinds of fill apart. Misaligned half-word and word addresses, a toggle of the order pin after reset, address aliasing, a read on a write cycle, and the last word of the array cover the remaining boundaries.

// File: rtl/memport_pkg.sv
// Shared definitions for the sub-word memory port.
// Assumes words of four 8-bit lanes; lane 0 is bits 7..0.
package memport_pkg;

    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Number of bytes moved by a size code (codes 2 and 3 both mean a word).
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Lane of the least significant byte of an access.
    // Little order: the offset itself. Big order: 4 - offset - size.
    function automatic logic [1:0] low_lane(input logic [1:0] sz,
                                            input logic [1:0] off,
                                            input logic       big);
        logic [2:0] tmp;
        tmp = big ? (3'd4 - {1'b0, off} - size_bytes(sz)) : {1'b0, off};
        return tmp[1:0];
    endfunction

endpackage

// File: rtl/memport_lane_map.sv
// Turns a request into lane terms: lowest lane used, byte enables,
// write data moved into its lanes, and the misalignment flag.
// Assumes the byte-order bit is already stable.
module memport_lane_map
    import memport_pkg::*;
(
    input  logic [1:0]        size_i,
    input  logic [1:0]        off_i,
    input  logic              big_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [1:0]        shift_o,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] wlanes_o,
    output logic              mis_o
);
    logic [LANES-1:0] mask;

    // Lane placement and enable mask for the requested size.
    always_comb begin
        shift_o  = low_lane(size_i, off_i, big_i);
        case (size_i)
            SZ_BYTE: mask = 4'b0001;
            SZ_HALF: mask = 4'b0011;
            default: mask = 4'b1111;
        endcase
        be_o     = mask << shift_o;
        wlanes_o = wdata_i << {shift_o, 3'b000};
    end

    // Alignment rule: half-words on even, words on multiple-of-four addresses.
    always_comb begin
        case (size_i)
            SZ_BYTE: mis_o = 1'b0;
            SZ_HALF: mis_o = off_i[0];
            default: mis_o = |off_i;
        endcase
    end
endmodule

// File: rtl/memport_store.sv
// Word store kept as one byte array per lane, with byte-enable writes
// and a registered read of the old contents (read before write).
// Assumes DEPTH = 2**IDX_W; contents are not reset.
module memport_store
    import memport_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [WORD_W-1:0] wlanes_i,
    output logic [WORD_W-1:0] rword_o
);
    localparam int DEPTH = 2 ** IDX_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] cells [DEPTH];
        logic [7:0] rd_q;

        // Byte write for this lane when enabled.
        always_ff @(posedge clk) begin
            if (be_i[l]) cells[idx_i] <= wlanes_i[8*l +: 8];
        end

        // Registered read of this lane; cleared in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= 8'h00;
            else        rd_q <= cells[idx_i];
        end

        assign rword_o[8*l +: 8] = rd_q;
    end
endmodule

// File: rtl/memport_widen.sv
// Pulls the addressed bytes out of a stored word and widens them
// to 32 bits with sign or zero fill. Assumes an aligned lane position.
module memport_widen
    import memport_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        shift_i,
    input  logic [1:0]        size_i,
    input  logic              sgn_i,
    output logic [WORD_W-1:0] data_o
);
    logic [WORD_W-1:0] lanes;

    // Right-align the access, then fill the upper bits.
    always_comb begin
        lanes = word_i >> {shift_i, 3'b000};
        case (size_i)
            SZ_BYTE: data_o = {{24{sgn_i & lanes[7]}},  lanes[7:0]};
            SZ_HALF: data_o = {{16{sgn_i & lanes[15]}}, lanes[15:0]};
            default: data_o = lanes;
        endcase
    end
endmodule

// File: rtl/mem_subword_port.sv
// Byte-addressable word memory with one sub-word load/store port.
// The byte order is captured while reset is low. A read happens every
// cycle and returns one clock later. Misaligned accesses flag err_o,
// do not write, and return zero. Assumes DEPTH is a power of two.
module mem_subword_port
    import memport_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              endian_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              signed_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              err_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              endian_q;
    logic [1:0]        shift;
    logic [LANES-1:0]  be_raw;
    logic [LANES-1:0]  byte_en;
    logic [WORD_W-1:0] wlanes;
    logic              mis;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] widened;
    logic [1:0]        shift_q;
    logic [1:0]        size_q;
    logic              sgn_q;
    logic              err_q;
    logic              unused_hi;

    assign idx       = addr_i[IDX_W+1:2];
    assign unused_hi = ^addr_i[ADDR_W-1:IDX_W+2];

    // Byte-order mode: follows the pin during reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) endian_q <= endian_sel_i;
    end

    memport_lane_map u_map (
        .size_i   (size_i),
        .off_i    (addr_i[1:0]),
        .big_i    (endian_q),
        .wdata_i  (wdata_i),
        .shift_o  (shift),
        .be_o     (be_raw),
        .wlanes_o (wlanes),
        .mis_o    (mis)
    );

    assign byte_en = (we_i && !mis) ? be_raw : '0;
    assign err_o   = mis;

    memport_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_i    (idx),
        .be_i     (byte_en),
        .wlanes_i (wlanes),
        .rword_o  (rword)
    );

    // Carry the request's shape alongside the registered read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= 2'd0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            shift_q <= shift;
            size_q  <= size_i;
            sgn_q   <= signed_i;
            err_q   <= mis;
        end
    end

    memport_widen u_widen (
        .word_i  (rword),
        .shift_i (shift_q),
        .size_i  (size_q),
        .sgn_i   (sgn_q),
        .data_o  (widened)
    );

    assign rdata_o = err_q ? '0 : widened;
endmodule

// File: rtl/memport_chk.sv
// Property checker for mem_subword_port, attached with bind.
// Relates the ports to the held byte order and the write enables.
module memport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  size_i,
    input logic        signed_i,
    input logic        we_i,
    input logic        err_o,
    input logic [31:0] rdata_o,
    input logic        endian_q,
    input logic [3:0]  byte_en
);
    // R4: the byte order never moves once reset is released.
    a_r4_endian_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(endian_q));

    // R5: no lane is written without a write request.
    a_r5_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |-> byte_en == 4'b0000);

    // R6: an unsigned byte read returns zeros above bit 7.
    a_r6_zero_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0 && !signed_i) |=> rdata_o[31:8] == 24'h0);

    // R6: an unsigned half-word read returns zeros above bit 15.
    a_r6_zero_ext_half: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd1 && !signed_i) |=> rdata_o[31:16] == 16'h0);

    // R6: a signed byte read copies bit 7 upward.
    a_r6_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0 && signed_i) |=> rdata_o[31:8] == {24{rdata_o[7]}});

    // R7: a misaligned access enables no lane.
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> byte_en == 4'b0000);

    // R7: the result after a misaligned access is zero.
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> rdata_o == 32'h0);
endmodule

bind mem_subword_port memport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .size_i   (size_i),
    .signed_i (signed_i),
    .we_i     (we_i),
    .err_o    (err_o),
    .rdata_o  (rdata_o),
    .endian_q (endian_q),
    .byte_en  (byte_en)
);

// File: tb/sim_mem_subword_port.sv
`timescale 1ns/100ps
module sim_mem_subword_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        endian_sel = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = 2'd0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        sgn = 1'b0;
    logic [31:0] rdata;
    logic        err;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mem_subword_port u0 (
        .clk(clk), .rst_n(rst_n), .endian_sel_i(endian_sel), .addr_i(addr),
        .size_i(size), .we_i(we), .wdata_i(wdata), .signed_i(sgn),
        .rdata_o(rdata), .err_o(err)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        sgn;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    // Little-endian walk (byte order captured as 0).
    localparam vec_t TBL [20] = '{
        '{1'b1, 32'h000, 2'd2, 1'b0, 32'h8899AABB, 32'h0,        1'b0, 4'd1}, // R1 word write
        '{1'b0, 32'h000, 2'd2, 1'b0, 32'h0,        32'h8899AABB, 1'b0, 4'd1}, // R1 word read
        '{1'b0, 32'h000, 2'd0, 1'b0, 32'h0,        32'h000000BB, 1'b0, 4'd2}, // R2 byte 0
        '{1'b0, 32'h001, 2'd0, 1'b1, 32'h0,        32'hFFFFFFAA, 1'b0, 4'd6}, // R6 signed neg
        '{1'b0, 32'h003, 2'd0, 1'b0, 32'h0,        32'h00000088, 1'b0, 4'd2}, // R2 byte 3
        '{1'b0, 32'h002, 2'd1, 1'b1, 32'h0,        32'hFFFF8899, 1'b0, 4'd6}, // R6 signed half
        '{1'b0, 32'h000, 2'd1, 1'b0, 32'h0,        32'h0000AABB, 1'b0, 4'd2}, // R2 half 0
        '{1'b1, 32'h001, 2'd0, 1'b0, 32'h12345677, 32'h0,        1'b0, 4'd5}, // R5 byte write
        '{1'b0, 32'h000, 2'd2, 1'b0, 32'h0,        32'h889977BB, 1'b0, 4'd5}, // R5 merge
        '{1'b1, 32'h002, 2'd1, 1'b0, 32'h00001234, 32'h0,        1'b0, 4'd5}, // R5 half write
        '{1'b0, 32'h000, 2'd2, 1'b0, 32'h0,        32'h123477BB, 1'b0, 4'd5}, // R5 merge
        '{1'b0, 32'h002, 2'd1, 1'b1, 32'h0,        32'h00001234, 1'b0, 4'd6}, // R6 signed pos
        '{1'b1, 32'h001, 2'd2, 1'b0, 32'hDEADBEEF, 32'h0,        1'b1, 4'd7}, // R7 bad word write
        '{1'b0, 32'h000, 2'd2, 1'b0, 32'h0,        32'h123477BB, 1'b0, 4'd7}, // R7 unchanged
        '{1'b0, 32'h001, 2'd1, 1'b0, 32'h0,        32'h0,        1'b1, 4'd7}, // R7 odd half
        '{1'b0, 32'h002, 2'd2, 1'b0, 32'h0,        32'h0,        1'b1, 4'd7}, // R7 word off 2
        '{1'b0, 32'h003, 2'd0, 1'b1, 32'h0,        32'h00000012, 1'b0, 4'd6}, // R6 signed byte pos
        '{1'b1, 32'h3FC, 2'd2, 1'b0, 32'hCAFEF00D, 32'h0,        1'b0, 4'd1}, // R1 last word
        '{1'b0, 32'h400, 2'd2, 1'b0, 32'h0,        32'h123477BB, 1'b0, 4'd1}, // R1 alias
        '{1'b0, 32'h000, 2'd3, 1'b0, 32'h0,        32'h123477BB, 1'b0, 4'd6}  // R6 code 3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one access at a falling edge; check err now and rdata a cycle later.
    task automatic access(input string tag, input logic w, input logic [31:0] a,
                          input logic [1:0] s, input logic sg, input logic [31:0] d,
                          input logic chk_rd, input logic [31:0] exp, input logic exp_err);
        we = w; addr = a; size = s; sgn = sg; wdata = d;
        #1;
        check({tag, " err"}, {31'h0, err}, {31'h0, exp_err});
        @(negedge clk);
        we = 1'b0;
        if (chk_rd) check({tag, " rdata"}, rdata, exp);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 reset rdata", rdata, 32'h0);
        end
        rst_n = 1'b1;
        endian_sel = 1'b1;                      // R4: ignored after release
        check("R9 first cycle rdata", rdata, 32'h0);
        for (int i = 0; i < 20; i++) begin
            access($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].we, TBL[i].addr,
                   TBL[i].size, TBL[i].sgn, TBL[i].wdata, !TBL[i].we,
                   TBL[i].exp, TBL[i].err);
        end
        access("R1 last word read", 1'b0, 32'h3FC, 2'd2, 1'b0, 0, 1'b1, 32'hCAFEF00D, 1'b0);
        access("R4 order pin ignored", 1'b0, 32'h000, 2'd0, 1'b0, 0, 1'b1, 32'h000000BB, 1'b0);

        // Second reset selects big-endian order.
        rst_n = 1'b0;
        endian_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 reset rdata", rdata, 32'h0);
        end
        rst_n = 1'b1;
        endian_sel = 1'b0;                      // R4: ignored after release
        access("R9 contents kept, R3 byte 0", 1'b0, 32'h000, 2'd0, 1'b0, 0, 1'b1, 32'h00000012, 1'b0);
        access("R3 word write", 1'b1, 32'h010, 2'd2, 1'b0, 32'h11223344, 1'b0, 0, 1'b0);
        access("R3 word same", 1'b0, 32'h010, 2'd2, 1'b0, 0, 1'b1, 32'h11223344, 1'b0);
        access("R3 byte 0", 1'b0, 32'h010, 2'd0, 1'b0, 0, 1'b1, 32'h00000011, 1'b0);
        access("R3 byte 3", 1'b0, 32'h013, 2'd0, 1'b0, 0, 1'b1, 32'h00000044, 1'b0);
        access("R3 half 0", 1'b0, 32'h010, 2'd1, 1'b0, 0, 1'b1, 32'h00001122, 1'b0);
        access("R3 half 2", 1'b0, 32'h012, 2'd1, 1'b0, 0, 1'b1, 32'h00003344, 1'b0);
        access("R5 big byte write", 1'b1, 32'h011, 2'd0, 1'b0, 32'h000000AB, 1'b0, 0, 1'b0);
        access("R5 big merge", 1'b0, 32'h010, 2'd2, 1'b0, 0, 1'b1, 32'h11AB3344, 1'b0);
        access("R6 big signed byte", 1'b0, 32'h011, 2'd0, 1'b1, 0, 1'b1, 32'hFFFFFFAB, 1'b0);
        access("R7 big odd half", 1'b0, 32'h013, 2'd1, 1'b1, 0, 1'b1, 32'h0, 1'b1);
        access("R8 first write", 1'b1, 32'h020, 2'd2, 1'b0, 32'h55667788, 1'b0, 0, 1'b0);
        access("R8 read before write", 1'b1, 32'h020, 2'd2, 1'b0, 32'h01020304, 1'b1, 32'h55667788, 1'b0);
        access("R8 new value", 1'b0, 32'h020, 2'd2, 1'b0, 0, 1'b1, 32'h01020304, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule